// File: doc/BRIEF.md
# Gated Capture/Compare Timer Channel

This block is one general-purpose timer channel. It has a 16-bit up-counter that advances on ticks from a selectable source: the system clock, the system clock divided by 16, or rising edges of the timer input pin. An 8-bit prescaler thins that source before it reaches the counter. When the counter reaches a programmed reference value, the channel raises a reference event. It then either keeps counting or restarts from zero, and it drives the timer output pin with a short low pulse or a toggle. Edges on the timer input pin can latch the live count into a capture register. A gate pin, when enabled, starts and stops counting. A separate gate-mode select input decides whether the gate's opening edge also clears the count.

Software reaches the channel through a plain single-cycle register port. A write takes effect on the clock edge where `wr_en_i` is high. Reads are combinational from `addr_i`, so every access finishes in one cycle and no back-pressure exists. The timer input and gate pins are asynchronous. Each passes through a two-stage synchronizer, and its edges are detected in the system-clock domain. As a result, any pin edge acts three clock edges after the pin changes.

Top module: `gptimer_ch`

## Requirements
- R1: After reset, every register (mode, reference, capture, count, events) reads 0, `tout_o` is high and `irq_o` is low.
- R2: The prescaler field (mode bits 15..8) divides the selected source by its value plus one, so 0 gives a counter tick per source tick and 255 gives one per 256.
- R3: The clock-select field (mode bits 2..1) picks the source: 00 stops counting, 01 uses every system clock, 10 uses every 16th system clock, 11 uses synchronized rising edges of `tin_i`.
- R4: With the restart bit (mode bit 3) at 0, the count keeps incrementing past the reference value and wraps from 0xFFFF to 0.
- R5: With the restart bit at 1, a tick that would bring the count to the reference value loads 0 instead.
- R6: Event register bit 1 is set by a reference match, and bit 0 by a capture. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a new event wins over a clear in the same cycle.
- R7: `irq_o` is high when (event bit 0 is set and the capture-edge field is non-zero) or (event bit 1 is set and the reference-interrupt bit, mode bit 4, is 1). The reference-interrupt bit has no effect on the capture term.
- R8: The capture-edge field (mode bits 7..6) selects which synchronized `tin_i` edges latch the current count into the capture register: 00 none, 01 rising only, 10 falling only, 11 both.
- R9: With output mode (mode bit 5) at 0, a reference match drives `tout_o` low until the next tick of the selected source, which is one source period.
- R10: With output mode at 1, `tout_o` inverts on every reference match.
- R11: With gate enable (mode bit 0) at 1 and `gate_mode_i` at 0, a falling `tgate_i` edge opens the gate and clears the count and prescaler, and a rising edge closes it. While the gate is closed the count does not move.
- R12: With gate enable at 1 and `gate_mode_i` at 1, a falling `tgate_i` edge opens the gate but keeps the count value.
- R13: Register addresses are 0 mode, 1 reference, 2 capture (writes ignored), 3 count (read/write), 4 events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| tin_i | input | 1 | Timer input pin: capture source or clock source |
| tgate_i | input | 1 | Gate pin |
| gate_mode_i | input | 1 | 0: gate opening restarts count, 1: it does not |
| tout_o | output | 1 | Timer output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check several relations on every cycle. A match always raises the reference flag and, when the interrupt is enabled, the request. A restart match leaves the count at zero. A capture latches the count of the preceding cycle. A closed gate freezes the count. The output pin pulses low or inverts after each match. Other behaviours need the bench's scenarios to show them: the prescaler ratios, the divide-by-16 and pin-driven sources, the wrap at 0xFFFF, the exact three-edge latency of pin edges, the end of the low pulse one source period later, and the difference between the two gate modes.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

  typedef enum logic [1:0] {
    CS_STOP = 2'b00,
    CS_SYS  = 2'b01,
    CS_DIV  = 2'b10,
    CS_TIN  = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_edge_e;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;

  localparam int unsigned EV_CAP = 0;
  localparam int unsigned EV_REF = 1;

endpackage

// File: rtl/gtm_pin_sync.sv
module gtm_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= (sync_q << 1) | STAGES'(pin_i);
      prev_q <= level;
    end
  end

  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;

endmodule

// File: rtl/gtm_tick_gen.sv
module gtm_tick_gen import gtm_pkg::*; #(
  parameter int unsigned PS_W  = 8,
  parameter int unsigned DIV_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sel_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            run_i,
  input  logic            tin_rise_i,
  input  logic            clr_i,
  output logic            src_tick_o,
  output logic            cnt_tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [PS_W-1:0]  pre_q;
  logic             src_raw;
  logic             pre_done;
  clk_src_e         sel;

  assign sel = clk_src_e'(sel_i);

  always_comb begin
    unique case (sel)
      CS_SYS:  src_raw = 1'b1;
      CS_DIV:  src_raw = &div_q;
      CS_TIN:  src_raw = tin_rise_i;
      default: src_raw = 1'b0;
    endcase
  end

  assign src_tick_o = src_raw & run_i;
  assign pre_done   = (pre_q >= ps_i);
  assign cnt_tick_o = src_tick_o & pre_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clr_i || sel != CS_DIV) begin
      div_q <= '0;
    end else if (run_i) begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr_i || sel == CS_STOP) begin
      pre_q <= '0;
    end else if (src_tick_o) begin
      pre_q <= pre_done ? '0 : pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/gtm_tout.sv
module gtm_tout (
  input  logic clk,
  input  logic rst_n,
  input  logic om_i,
  input  logic match_i,
  input  logic src_tick_i,
  output logic tout_o
);

  logic low_q;
  logic tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
    end else if (om_i) begin
      low_q <= 1'b0;
    end else if (match_i) begin
      low_q <= 1'b1;
    end else if (src_tick_i) begin
      low_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
    end else if (om_i && match_i) begin
      tgl_q <= ~tgl_q;
    end
  end

  assign tout_o = om_i ? tgl_q : ~low_q;

  // R9
  tout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!om_i && match_i) |=> (om_i || !tout_o));

  // R10
  tout_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (om_i && match_i) |=> (!om_i || tout_o != $past(tout_o)));

endmodule

// File: rtl/gptimer_ch.sv
module gptimer_ch import gtm_pkg::*; #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PS_W        = 8,
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              tin_i,
  input  logic              tgate_i,
  input  logic              gate_mode_i,
  output logic              tout_o,
  output logic              irq_o
);

  localparam int unsigned MODE_W  = PS_W + 8;
  localparam int unsigned B_GE    = 0;
  localparam int unsigned B_CS    = 1;
  localparam int unsigned B_FRR   = 3;
  localparam int unsigned B_ORI   = 4;
  localparam int unsigned B_OM    = 5;
  localparam int unsigned B_CE    = 6;
  localparam int unsigned B_PS    = 8;
  localparam int unsigned N_PINS  = 2;
  localparam int unsigned P_TIN   = 0;
  localparam int unsigned P_GATE  = 1;
  localparam int unsigned N_EVT   = 2;

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  ref_q;
  logic [CNT_W-1:0]  cap_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [N_EVT-1:0]  evt_q;
  logic              gate_open_q;

  logic              ge, frr, ori, om;
  logic [1:0]        cs;
  cap_edge_e         ce;
  logic [PS_W-1:0]   ps;

  assign ge  = mode_q[B_GE];
  assign cs  = mode_q[B_CS +: 2];
  assign frr = mode_q[B_FRR];
  assign ori = mode_q[B_ORI];
  assign om  = mode_q[B_OM];
  assign ce  = cap_edge_e'(mode_q[B_CE +: 2]);
  assign ps  = mode_q[B_PS +: PS_W];

  // Pin synchronizers
  logic [N_PINS-1:0] pin_raw, pin_rise, pin_fall;
  assign pin_raw[P_TIN]  = tin_i;
  assign pin_raw[P_GATE] = tgate_i;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    gtm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_raw[g]),
      .rise_o (pin_rise[g]),
      .fall_o (pin_fall[g])
    );
  end

  // Register write decode
  logic wr_mode, wr_ref, wr_cnt, wr_evt;
  assign wr_mode = wr_en_i && addr_i == A_MODE;
  assign wr_ref  = wr_en_i && addr_i == A_REF;
  assign wr_cnt  = wr_en_i && addr_i == A_CNT;
  assign wr_evt  = wr_en_i && addr_i == A_EVT;

  // Gating
  logic run, gate_clr;
  assign run      = (clk_src_e'(cs) != CS_STOP) && (!ge || gate_open_q);
  assign gate_clr = ge && pin_fall[P_GATE] && !gate_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_open_q <= 1'b0;
    end else if (pin_fall[P_GATE]) begin
      gate_open_q <= 1'b1;
    end else if (pin_rise[P_GATE]) begin
      gate_open_q <= 1'b0;
    end
  end

  // Tick generation
  logic src_tick, cnt_tick;

  gtm_tick_gen #(.PS_W(PS_W), .DIV_W(DIV_W)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (cs),
    .ps_i       (ps),
    .run_i      (run),
    .tin_rise_i (pin_rise[P_TIN]),
    .clr_i      (gate_clr),
    .src_tick_o (src_tick),
    .cnt_tick_o (cnt_tick)
  );

  // Counter and reference compare
  logic [CNT_W-1:0] cnt_next;
  logic             match;
  assign cnt_next = cnt_q + 1'b1;
  assign match    = cnt_tick && (cnt_next == ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (gate_clr) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata_i;
    end else if (cnt_tick) begin
      cnt_q <= (match && frr) ? '0 : cnt_next;
    end
  end

  // Capture
  logic cap_hit;
  always_comb begin
    unique case (ce)
      CAP_RISE: cap_hit = pin_rise[P_TIN];
      CAP_FALL: cap_hit = pin_fall[P_TIN];
      CAP_BOTH: cap_hit = pin_rise[P_TIN] | pin_fall[P_TIN];
      default:  cap_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_hit) begin
      cap_q <= cnt_q;
    end
  end

  // Mode and reference registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata_i[MODE_W-1:0];
      if (wr_ref)  ref_q  <= wdata_i;
    end
  end

  // Event flags: set wins over write-one-to-clear
  logic [N_EVT-1:0] evt_set;
  assign evt_set[EV_CAP] = cap_hit;
  assign evt_set[EV_REF] = match;

  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt_q[e] <= 1'b0;
      end else if (evt_set[e]) begin
        evt_q[e] <= 1'b1;
      end else if (wr_evt && wdata_i[e]) begin
        evt_q[e] <= 1'b0;
      end
    end
  end

  assign irq_o = (evt_q[EV_CAP] && ce != CAP_OFF) || (evt_q[EV_REF] && ori);

  // Output pin
  gtm_tout u_tout (
    .clk        (clk),
    .rst_n      (rst_n),
    .om_i       (om),
    .match_i    (match),
    .src_tick_i (src_tick),
    .tout_o     (tout_o)
  );

  // Read mux
  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = CNT_W'(mode_q);
      A_REF:   rdata_o = ref_q;
      A_CAP:   rdata_o = cap_q;
      A_CNT:   rdata_o = cnt_q;
      A_EVT:   rdata_o = CNT_W'(evt_q);
      default: rdata_o = '0;
    endcase
  end

  // R6
  ref_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> evt_q[EV_REF]);

  // R7
  irq_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && ori && !wr_mode) |=> irq_o);

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && frr && !wr_cnt) |=> (cnt_q == '0));

  // R8
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (cap_q == $past(cnt_q)));

  // R11
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ge && !gate_open_q && !gate_clr && !wr_cnt) |=> $stable(cnt_q));

endmodule

// File: tb/gptimer_ch_bench.sv
module gptimer_ch_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        tin = 1'b0;
  logic        tgate = 1'b1;
  logic        gmode = 1'b0;
  logic        tout;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gptimer_ch u_gptimer_ch (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .tin_i       (tin),
    .tgate_i     (tgate),
    .gate_mode_i (gmode),
    .tout_o      (tout),
    .irq_o       (irq)
  );

  localparam logic [2:0] AM = 3'd0, AR = 3'd1, AC = 3'd2, AN = 3'd3, AE = 3'd4;

  typedef struct packed {
    logic [1:0]  cs;
    logic [7:0]  ps;
    logic        frr;
    logic [15:0] rf;
    logic [15:0] n;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'd0,   1'b0, 16'd100,  16'd50},
    '{2'd1, 8'd0,   1'b0, 16'd30,   16'd50},
    '{2'd1, 8'd0,   1'b1, 16'd20,   16'd50},
    '{2'd1, 8'd3,   1'b0, 16'd1000, 16'd100},
    '{2'd1, 8'd3,   1'b1, 16'd7,    16'd100},
    '{2'd2, 8'd0,   1'b0, 16'd500,  16'd200},
    '{2'd2, 8'd1,   1'b1, 16'd5,    16'd400},
    '{2'd1, 8'd255, 1'b0, 16'd9,    16'd600},
    '{2'd0, 8'd0,   1'b0, 16'd5,    16'd50}
  };

  function automatic int ticks_of(vec_t v);
    int src;
    src = (v.cs == 2'd1) ? int'(v.n) : (v.cs == 2'd2) ? int'(v.n) / 16 : 0;
    return src / (int'(v.ps) + 1);
  endfunction

  function automatic int exp_cnt(vec_t v);
    int k;
    k = ticks_of(v);
    if (v.frr) return k % int'(v.rf);
    return k % 65536;
  endfunction

  function automatic int exp_flag(vec_t v);
    return (ticks_of(v) >= int'(v.rf)) ? 1 : 0;
  endfunction

  function automatic logic [15:0] mk(input logic [7:0] ps, input logic [1:0] ce,
                                     input logic om, input logic ori, input logic frr,
                                     input logic [1:0] cs, input logic ge);
    return {ps, ce, om, ori, frr, cs, ge};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prep(input logic [15:0] rf, input logic [15:0] c);
    wr(AM, 16'd0);
    wr(AN, c);
    wr(AE, 16'd3);
    wr(AR, rf);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    finish_run();
  end

  initial begin
    int d, c0, c1;
    run(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(AM, d); chk("R1 mode", d, 0);
    rd(AR, d); chk("R1 ref", d, 0);
    rd(AC, d); chk("R1 cap", d, 0);
    rd(AN, d); chk("R1 cnt", d, 0);
    rd(AE, d); chk("R1 evt", d, 0);
    chk("R1 tout", int'(tout), 1);
    chk("R1 irq", int'(irq), 0);

    // R2 R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      prep(VECS[i].rf, 16'd0);
      wr(AM, mk(VECS[i].ps, 2'd0, 1'b0, 1'b0, VECS[i].frr, VECS[i].cs, 1'b0));
      run(int'(VECS[i].n));
      rd(AN, d); chk($sformatf("R2/R3/R5 vec%0d cnt", i), d, exp_cnt(VECS[i]));
      rd(AE, d); chk($sformatf("R4/R6 vec%0d refflag", i), (d >> 1) & 1, exp_flag(VECS[i]));
    end

    // R4 wrap
    prep(16'd5, 16'hFFFE);
    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0));
    run(3);
    rd(AN, d); chk("R4 wrap", d, 1);

    // R10 toggle, R5 restart
    prep(16'd4, 16'd0);
    wr(AM, mk(8'd0, 2'd0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0));
    run(3); chk("R10 before match", int'(tout), 0);
    run(1); chk("R10 first toggle", int'(tout), 1);
    rd(AN, d); chk("R5 restart to zero", d, 0);
    run(4); chk("R10 second toggle", int'(tout), 0);

    // R9 pulse on system clock
    prep(16'd4, 16'd0);
    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0));
    run(4); chk("R9 pulse low", int'(tout), 0);
    run(1); chk("R9 pulse end", int'(tout), 1);

    // R9 pulse with /16 source
    prep(16'd2, 16'd0);
    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0));
    run(32); chk("R9 div16 low", int'(tout), 0);
    run(15); chk("R9 div16 still low", int'(tout), 0);
    run(1);  chk("R9 div16 end", int'(tout), 1);

    // R7 reference interrupt, R6 write-one-to-clear
    prep(16'd3, 16'd0);
    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0));
    run(3); chk("R7 irq on ref", int'(irq), 1);
    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0));
    wr(AE, 16'd0);
    rd(AE, d); chk("R6 write zero keeps", d, 2);
    wr(AE, 16'd2);
    rd(AE, d); chk("R6 w1c", d, 0);
    chk("R7 irq cleared", int'(irq), 0);

    prep(16'd3, 16'd0);
    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0));
    run(3);
    rd(AE, d); chk("R6 flag without ori", d, 2);
    chk("R7 irq masked", int'(irq), 0);

    // R8 capture edges
    prep(16'd1000, 16'd0);
    wr(AM, mk(8'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0));
    run(10);
    tin = 1'b1;
    run(3);
    rd(AC, d); chk("R8 rising capture", d, 12);
    rd(AE, d); chk("R8 cap flag", d & 1, 1);
    chk("R7 capture irq independent of ori", int'(irq), 1);
    wr(AE, 16'd1);
    tin = 1'b0;
    run(4);
    rd(AE, d); chk("R8 falling ignored flag", d & 1, 0);
    rd(AC, d); chk("R8 falling ignored cap", d, 12);

    wr(AM, mk(8'd0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0));
    tin = 1'b1;
    run(4);
    rd(AE, d); chk("R8 rising ignored in falling mode", d & 1, 0);
    rd(AN, c1);
    tin = 1'b0;
    run(3);
    rd(AC, d); chk("R8 falling capture", d, c1 + 2);

    wr(AM, mk(8'd0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0));
    wr(AE, 16'd1);
    rd(AN, c0);
    tin = 1'b1;
    run(3);
    rd(AC, d); chk("R8 both-edge capture", d, c0 + 2);

    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0));
    wr(AE, 16'd1);
    tin = 1'b0;
    run(4);
    rd(AE, d); chk("R8 capture off flag", d & 1, 0);
    chk("R7 capture off irq", int'(irq), 0);

    // R3 pin as clock source
    prep(16'd1000, 16'd0);
    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0));
    for (int p = 0; p < 5; p++) begin
      tin = 1'b1; run(3);
      tin = 1'b0; run(3);
    end
    run(4);
    rd(AN, d); chk("R3 tin source", d, 5);

    // R11 gate with restart
    gmode = 1'b0;
    prep(16'd1000, 16'd100);
    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1));
    run(5);
    rd(AN, d); chk("R11 closed gate holds", d, 100);
    tgate = 1'b0;
    run(3);
    rd(AN, d); chk("R11 restart on open", d, 0);
    run(5);
    rd(AN, d); chk("R11 counting while open", d, 5);
    tgate = 1'b1;
    run(10);
    rd(AN, d); chk("R11 closes on rise", d, 8);

    // R12 gate without restart
    gmode = 1'b1;
    prep(16'd1000, 16'd100);
    wr(AM, mk(8'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1));
    run(5);
    tgate = 1'b0;
    run(8);
    rd(AN, d); chk("R12 open keeps count", d, 105);
    tgate = 1'b1;
    run(10);
    rd(AN, d); chk("R12 closes on rise", d, 108);

    // R13 register map
    wr(AM, 16'hA5F0);
    rd(AM, d); chk("R13 mode readback", d, 16'hA5F0);
    wr(AR, 16'h1234);
    rd(AR, d); chk("R13 ref readback", d, 16'h1234);
    rd(AC, c0);
    wr(AC, 16'hBEEF);
    rd(AC, d); chk("R13 capture write ignored", d, c0);
    wr(AN, 16'h0F0F);
    rd(AN, d); chk("R13 count write", d, 16'h0F0F);

    finish_run();
  end

endmodule